// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block is a slave receiver for a serial control port that is framed by a chip-select. It has three inputs: an active-low select, a serial clock and a serial data line. While select is low, the block shifts in one bit on each rising edge of the serial clock. When select returns high, it checks the frame. A valid frame updates one register in a small bank of eight-bit configuration registers. The contents of the whole bank are always available as one flattened parallel bus.

A frame has sixteen bits. The first three bits are an operation code, the next five are a register address and the last eight are the register value. Each field is sent least significant bit first. A frame is a write only when the last operation-code bit is 1. The block commits a frame only if exactly sixteen rising clock edges occurred while select was low, and only if the address is inside the writable window. All other frames are dropped. The serial lines are resynchronised into the system clock domain, so the serial clock must be much slower than the system clock.

Top module: `cfg_write_port`

## Requirements
- R1: After system reset every register output reads zero.
- R2: In a frame, bit 0 is sent first. Bits 0..2 are the opcode, bits 3..7 are the address (address bit 0 first) and bits 8..15 are the data (data bit 0 first). A committed frame stores its data in the register whose index equals the address. Register k occupies bits 8k+7..8k of the output bus.
- R3: The data line is sampled at rising edges of the serial clock. A data line that changes only while the serial clock is low is captured correctly.
- R4: A write takes effect only after select rises. After the sixteenth edge, and while select is still low, the addressed register keeps its old value.
- R5: A frame is a write only if opcode bit 2 is 1. Opcode bits 0 and 1 are ignored. A frame with opcode bit 2 equal to 0 changes no register.
- R6: A frame whose address is 5 or higher changes no register.
- R7: A frame that had fewer or more than sixteen rising serial-clock edges while select was low changes no register.
- R8: The bit count and the shift contents are cleared while select is high. A valid frame that follows an aborted partial frame is therefore received correctly.
- R9: A committed write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low frame select, high when idle |
| sclk | input | 1 | Serial clock, data captured on rising edges |
| sdi | input | 1 | Serial data, LSB-first per field |
| regs_o | output | NUM_REGS*DATA_W (40) | Register bank contents, register k at bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: five eight-bit registers, a five-bit address, a three-bit opcode and two synchroniser stages. With these defaults the smallest rejected address (5), the largest writable address (4) and the unused upper addresses are all reachable in short frames. The serial clock runs at one eighth of the system clock, so every frame passes through the synchroniser well inside one serial half-period. Edge counts of 15, 16 and 17, mid-frame observation before select rises, and an aborted partial frame cover the framing corners.

// File: rtl/cfg_write_pkg.sv
package cfg_write_pkg;
  localparam int unsigned OP_W     = 3;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FRAME_W  = OP_W + ADDR_W + DATA_W;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    logic [OP_W-1:0]   op;
  } frame_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned WIDTH     = 1,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else begin
        if (s == 0) stage_q[s] <= d_i;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_write_pkg::*;
#(
  parameter int unsigned NUM_REGS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

  logic               sel_q, sclk_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               wr_en_d;
  frame_t             frm;

  logic sclk_rise, sel_rise;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sel_rise  = sel_s & ~sel_q;
  assign frm       = frame_t'(sh_q);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (sel_s) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (sclk_rise) begin
      sh_d = {sdi_s, sh_q[FRAME_W-1:1]};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    wr_en_d = sel_rise && (cnt_q == CNT_FULL) && frm.op[OP_W-1]
              && (frm.addr < ADDR_W'(NUM_REGS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b1;
      sclk_q    <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      sel_q   <= sel_s;
      sclk_q  <= sclk_s;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      wr_en_o <= wr_en_d;
      if (wr_en_d) begin
        wr_addr_o <= frm.addr;
        wr_data_o <= frm.data;
      end
    end
  end

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (cnt_q == '0));

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R4
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_write_pkg::*;
#(
  parameter int unsigned NUM_REGS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic              ld;
    logic [DATA_W-1:0] val_q;
    assign ld = wr_en_i && (wr_addr_i == ADDR_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (ld) val_q <= wr_data_i;
    end
    assign regs_o[k*DATA_W +: DATA_W] = val_q;
  end

  // R6
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (wr_addr_i < ADDR_W'(NUM_REGS)));

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(regs_o));
endmodule

// File: rtl/cfg_write_port.sv
module cfg_write_port
  import cfg_write_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [2:0]        line_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({sel_n, sclk, sdi}),
    .q_o   (line_s)
  );

  cfg_frame_rx #(.NUM_REGS(NUM_REGS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sel_s     (line_s[2]),
    .sclk_s    (line_s[1]),
    .sdi_s     (line_s[0]),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .regs_o    (regs_o)
  );
endmodule

// File: tb/cfg_write_port_bench.sv
module cfg_write_port_bench;
  localparam int NREG = 5;

  typedef struct packed {
    logic [2:0] op;
    logic [4:0] addr;
    logic [7:0] data;
    logic [4:0] edges;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{3'b100, 5'd0,  8'hA5, 5'd16},  // R2 reg0
    '{3'b111, 5'd4,  8'h3C, 5'd16},  // R2 top address, R5 don't-care bits
    '{3'b101, 5'd1,  8'h81, 5'd16},  // R2 R9
    '{3'b110, 5'd2,  8'h5A, 5'd16},  // R2
    '{3'b100, 5'd3,  8'hF0, 5'd16},  // R2
    '{3'b011, 5'd1,  8'hEE, 5'd16},  // R5 not a write
    '{3'b100, 5'd5,  8'h77, 5'd16},  // R6 first outside address
    '{3'b100, 5'd31, 8'h11, 5'd16},  // R6
    '{3'b100, 5'd2,  8'h99, 5'd15},  // R7 short
    '{3'b100, 5'd3,  8'h42, 5'd17},  // R7 long
    '{3'b100, 5'd0,  8'h01, 5'd16},  // R2 R9
    '{3'b100, 5'd4,  8'h80, 5'd16}   // R2 MSB data bit
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [NREG*8-1:0] regs_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [NREG];

  always #10 clk = ~clk;

  cfg_write_port u_cfg_write_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n),
    .sclk(sclk), .sdi(sdi), .regs_o(regs_o)
  );

  function automatic logic [NREG*8-1:0] model_bus();
    logic [NREG*8-1:0] b;
    for (int k = 0; k < NREG; k++) b[k*8 +: 8] = mdl[k];
    return b;
  endfunction

  task automatic check(string req, logic [NREG*8-1:0] act, logic [NREG*8-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // data changes only while sclk is low (R3)
  task automatic clock_bits(logic [15:0] frame, int nedges, int first);
    for (int i = first; i < first + nedges; i++) begin
      sdi = (i < 16) ? frame[i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic release_sel();
    wait_clk(4);
    sel_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic send(logic [2:0] op, logic [4:0] addr, logic [7:0] data, int nedges);
    sel_n = 1'b0;
    wait_clk(4);
    clock_bits({data, addr, op}, nedges, 0);
    release_sel();
    if (nedges == 16 && op[2] && addr < NREG) mdl[addr] = data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 reset", regs_o, '0);

    for (int v = 0; v < NVEC; v++) begin
      send(VECS[v].op, VECS[v].addr, VECS[v].data, int'(VECS[v].edges));
      check("R2/R3/R5/R6/R7/R9 vector", regs_o, model_bus());
    end

    // R4: after sixteen edges, register unchanged until select rises
    sel_n = 1'b0;
    wait_clk(4);
    clock_bits({8'hC3, 5'd2, 3'b100}, 16, 0);
    wait_clk(12);
    check("R4 before select release", regs_o, model_bus());
    release_sel();
    mdl[2] = 8'hC3;
    check("R4 after select release", regs_o, model_bus());

    // R8: aborted partial frame, then a good frame
    sel_n = 1'b0;
    wait_clk(4);
    clock_bits(16'hFFFF, 9, 0);
    release_sel();
    check("R8 aborted frame no change", regs_o, model_bus());
    send(3'b100, 5'd1, 8'h6D, 16);
    check("R8 frame after abort", regs_o, model_bus());

    // R1: reset in the middle of operation clears every register
    rst_n = 1'b0;
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(5);
    for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
    check("R1 reset after writes", regs_o, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule